// File: doc/BRIEF.md
# Quadrature Decoder with Position Counter

This block turns the two phase signals of a rotary or linear encoder, plus its once-per-revolution index signal, into a signed-free 32-bit position count, a count of index pulses and a direction flag. The phase and index pins are asynchronous to the system clock. They pass through a two-flop synchroniser, and edges are found on the synchronised copies.

The count rule is picked at run time from a configuration word. In quadrature mode the phase relationship gives the direction, and either phase A edges alone (2X) or the edges of both phases (4X) are counted. In step/direction mode phase A is a direction level and every rising edge of phase B is one step.

A control word carries one-shot commands: an immediate clear of the position, a clear of the position armed for the next index pulse, and a clear of the index count. Each command bit drops back to 0 by itself once its action has been done. Software reaches the words through a simple single-cycle register port.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the position count, the index count, the direction status and every register read back 0.
- R2: Register map by `reg_addr`: 0 is control, 1 is status, 2 is configuration, and 3 reads 0. Control bits 31:4 and bit 2, configuration bits 31:4 and status bits 31:1 read 0. Writing to status or to address 3 has no effect.
- R3: Writing 1 to control bit 0 clears the position count to 0, and the bit then reads back 0.
- R4: Writing 1 to control bit 1 arms a clear. The bit reads back 1 and the position keeps counting until the next rising edge of the effective index. On that edge the position becomes 0 and the bit returns to 0.
- R5: Writing 1 to control bit 3 clears the index count to 0, and the bit then reads back 0.
- R6: Quadrature 4X mode (configuration bit 1 = 0, bit 2 = 1). The forward sequence of {A,B} is 00, 10, 11, 01. Each step forward adds 1 to the position and each step backward subtracts 1.
- R7: Quadrature 2X mode (configuration bit 1 = 0, bit 2 = 0). Only phase A edges change the position, by +1 forward and by -1 in reverse. Phase B edges leave the position unchanged.
- R8: Step/direction mode (configuration bit 1 = 1). Each rising edge of phase B adds 1 to the position when phase A is high and subtracts 1 when phase A is low. Falling edges of phase B and any change of phase A leave the position unchanged.
- R9: The decoded direction is 1 for forward. Status bit 0 and `dir_out` show that direction exclusive-ORed with configuration bit 0.
- R10: The index count adds 1 on each rising edge of the effective index, which is the index pin exclusive-ORed with configuration bit 3. Changing configuration bit 3 by itself does not count.
- R11: When a clear command takes effect in the same cycle as a count edge, the position becomes 0.
- R12: The position wraps modulo 2^32 in both directions: 0 minus one step is 0xFFFFFFFF, and one step up from there is 0.
- R13: A change on a phase pin reaches the position count on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Encoder phase A, or direction level in step mode |
| phase_b | input | 1 | Encoder phase B, or step clock in step mode |
| index_in | input | 1 | Encoder index pin |
| reg_wr | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pos_count | output | 32 | Position count |
| idx_count | output | 32 | Index pulse count |
| dir_out | output | 1 | Direction status, with the inversion applied |

## Verification
The assertions assume that each phase or index pin changes at most once per few clock cycles, so that every synchronised edge is seen on its own. They also assume that the phase pins follow the legal quadrature sequence, so A and B never change in the same cycle. The bench keeps to this by moving one pin at a time and waiting four clock cycles after each move, which is longer than the three-edge latency. The one place where timing is forced is the reset-versus-count case. There a control write is placed so that the clear and the count edge reach the position register on the same edge.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [CNT_W-1:0] pos_count,
  output logic [CNT_W-1:0] idx_count,
  output logic             dir_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0] a_sy, b_sy, i_sy;
  logic       a_d, b_d, i_d;
  logic       ctl_pos, ctl_arm, ctl_idx;
  logic [3:0] cfg;
  logic       dir_q;
  logic [CNT_W-1:0] pos_q, idx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sy <= '0; b_sy <= '0; i_sy <= '0;
      a_d  <= 1'b0; b_d <= 1'b0; i_d <= 1'b0;
    end else begin
      a_sy <= {a_sy[0], phase_a};
      b_sy <= {b_sy[0], phase_b};
      i_sy <= {i_sy[0], index_in};
      a_d  <= a_sy[1];
      b_d  <= b_sy[1];
      i_d  <= i_sy[1];
    end

  wire a_s = a_sy[1];
  wire b_s = b_sy[1];
  wire a_edge = a_s ^ a_d;
  wire b_edge = b_s ^ b_d;

  wire cfg_dinv = cfg[0];
  wire cfg_step = cfg[1];
  wire cfg_x4   = cfg[2];
  wire cfg_iinv = cfg[3];

  wire idx_rise = (i_sy[1] ^ cfg_iinv) & ~(i_d ^ cfg_iinv);

  wire q_a_cnt = a_edge & ~b_edge;
  wire q_b_cnt = b_edge & ~a_edge & cfg_x4;
  wire q_fwd   = q_a_cnt ? (b_s != a_s) : (a_s == b_s);
  wire s_cnt   = b_edge & b_s;

  wire cnt_en  = cfg_step ? s_cnt : (q_a_cnt | q_b_cnt);
  wire cnt_fwd = cfg_step ? a_s   : q_fwd;

  wire wr_ctl = reg_wr && reg_addr == 2'd0;
  wire wr_cfg = reg_wr && reg_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_pos <= 1'b0; ctl_arm <= 1'b0; ctl_idx <= 1'b0;
      cfg     <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_pos <= reg_wdata[0];
        ctl_arm <= reg_wdata[1];
        ctl_idx <= reg_wdata[3];
      end else begin
        ctl_pos <= 1'b0;
        ctl_idx <= 1'b0;
        if (idx_rise) ctl_arm <= 1'b0;
      end
      if (wr_cfg) cfg <= reg_wdata[3:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos_q <= '0;
      idx_q <= '0;
      dir_q <= 1'b0;
    end else begin
      if (ctl_pos || (ctl_arm && idx_rise)) pos_q <= '0;
      else if (cnt_en) pos_q <= cnt_fwd ? pos_q + ONE : pos_q - ONE;
      if (ctl_idx) idx_q <= '0;
      else if (idx_rise) idx_q <= idx_q + ONE;
      if (cnt_en) dir_q <= cnt_fwd;
    end

  assign pos_count = pos_q;
  assign idx_count = idx_q;
  assign dir_out   = dir_q ^ cfg_dinv;

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {28'd0, ctl_idx, 1'b0, ctl_arm, ctl_pos};
      2'd1:    reg_rdata = {31'd0, dir_out};
      2'd2:    reg_rdata = {28'd0, cfg};
      default: reg_rdata = '0;
    endcase

  logic unused_wd;
  assign unused_wd = ^{reg_wdata[31:4], reg_wdata[2]};

  a_r3_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_pos |=> pos_q == '0);

  a_r3_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pos && !wr_ctl) |=> !ctl_pos);

  a_r4_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_arm && idx_rise) |=> (pos_q == '0));

  a_r5_idx_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_idx && !wr_ctl) |=> (idx_q == '0 && !ctl_idx));

  a_r12_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pos_q == $past(pos_q) || pos_q == $past(pos_q) + ONE ||
              pos_q == $past(pos_q) - ONE || pos_q == '0));

  a_r10_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + ONE || idx_q == '0));

  a_r8_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_step && !b_edge && !ctl_pos && !ctl_arm) |=> $stable(pos_q));
endmodule

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic pa = 0, pb = 0, ix = 0;
  logic wr = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, pos, idx;
  logic dir;

  int checks = 0, fails = 0;
  bit done = 0;
  int qs = 0;
  logic [31:0] exp_pos = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_pos_counter u_quad_pos_counter (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb), .index_in(ix),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .pos_count(pos), .idx_count(idx), .dir_out(dir));

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 0; wdata = 0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_q(int s);
    qs = s & 3;
    case (qs)
      0: begin pa = 0; pb = 0; end
      1: begin pa = 1; pb = 0; end
      2: begin pa = 1; pb = 1; end
      default: begin pa = 0; pb = 1; end
    endcase
  endtask

  task automatic qstep(bit fwd, bit x4);
    int ns;
    bit a_moves;
    ns = fwd ? qs + 1 : qs + 3;
    a_moves = ((qs & 3) == 0 || (qs & 3) == 2) ? fwd : !fwd;
    @(negedge clk); set_q(ns);
    if (x4 || a_moves) exp_pos = fwd ? exp_pos + 1 : exp_pos - 1;
    settle();
  endtask

  task automatic bpulse(bit dirlvl);
    @(negedge clk); pa = dirlvl; settle();
    @(negedge clk); pb = 1; settle();
    exp_pos = dirlvl ? exp_pos + 1 : exp_pos - 1;
    chk("R8 rise", pos, exp_pos);
    @(negedge clk); pb = 0; settle();
    chk("R8 fall ignored", pos, exp_pos);
  endtask

  task automatic ipulse();
    @(negedge clk); ix = ~ix; settle();
    @(negedge clk); ix = ~ix; settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 pos", pos, 0); chk("R1 idx", idx, 0); chk("R1 dir", {31'd0, dir}, 0);
    for (int a = 0; a < 4; a++) begin rreg(a[1:0], r); chk("R1 reg", r, 0); end

    wreg(2, 32'hFFFF_FFFF); rreg(2, r); chk("R2 cfg mask", r, 32'h0000_000F);
    wreg(1, 32'hFFFF_FFFF); wreg(3, 32'hFFFF_FFFF);
    rreg(1, r); chk("R2 status upper", r & 32'hFFFF_FFFE, 0);
    rreg(3, r); chk("R2 addr3", r, 0);
    wreg(2, 0); wreg(0, 32'h0000_0004); rreg(0, r); chk("R2 ctl bit2", r, 0);

    for (int m = 0; m < 4; m++) begin
      bit x4, inv;
      x4 = m[0]; inv = m[1];
      wreg(2, {29'd0, x4, 1'b0, inv});
      wreg(0, 1); settle(); exp_pos = 0;
      chk("R3 clear", pos, 0);
      rreg(0, r); chk("R3 self clear", r, 0);
      for (int k = 0; k < 10; k++) qstep(1, x4);
      chk(x4 ? "R6 fwd" : "R7 fwd", pos, exp_pos);
      chk("R9 fwd dir", {31'd0, dir}, {31'd0, ~inv});
      rreg(1, r); chk("R9 status", r, {31'd0, ~inv});
      for (int k = 0; k < 6; k++) qstep(0, x4);
      chk(x4 ? "R6 rev" : "R7 rev", pos, exp_pos);
      chk("R9 rev dir", {31'd0, dir}, {31'd0, inv});
    end

    wreg(2, 32'h4); wreg(0, 1); settle(); exp_pos = 0;
    @(negedge clk); set_q(qs + 1);
    repeat (2) @(negedge clk); #1 chk("R13 not yet", pos, 0);
    @(negedge clk); #1 chk("R13 third edge", pos, 1);
    settle(); exp_pos = 1;

    wreg(0, 1); settle(); exp_pos = 0;
    qstep(0, 1); chk("R12 wrap down", pos, 32'hFFFF_FFFF);
    qstep(1, 1); chk("R12 wrap up", pos, 0);

    qstep(1, 1); qstep(1, 1);
    @(negedge clk); set_q(qs + 1);
    @(negedge clk); wr = 1; addr = 0; wdata = 1;
    @(negedge clk); wr = 0; wdata = 0;
    settle(); exp_pos = 0;
    chk("R11 reset wins", pos, 0);

    wreg(0, 2); qstep(1, 1); qstep(1, 1);
    chk("R4 armed still counts", pos, exp_pos);
    rreg(0, r); chk("R4 arm reads", r, 2);
    ipulse(); exp_pos = 0;
    chk("R4 index clear", pos, 0);
    rreg(0, r); chk("R4 disarm", r, 0);
    qstep(1, 1); ipulse();
    chk("R4 one shot", pos, exp_pos);

    wreg(0, 8); settle(); chk("R5 clear idx", idx, 0);
    ipulse(); ipulse(); ipulse(); chk("R10 count", idx, 3);
    wreg(2, 32'hC); settle(); chk("R10 inv alone", idx, 3);
    @(negedge clk); ix = 1; settle(); chk("R10 inv high", idx, 3);
    @(negedge clk); ix = 0; settle(); chk("R10 inv fall", idx, 4);
    wreg(0, 8); settle(); chk("R5 clear", idx, 0);
    rreg(0, r); chk("R5 self clear", r, 0);

    wreg(2, 32'h2); wreg(0, 1); settle(); exp_pos = 0;
    @(negedge clk); pa = 0; pb = 0; settle();
    for (int k = 0; k < 7; k++) bpulse(k < 5);
    chk("R8 total", pos, 3);
    @(negedge clk); pa = ~pa; settle(); chk("R8 A ignored", pos, 3);
    chk("R9 step dir", {31'd0, dir}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule